// File: doc/BRIEF.md
# Dual-Lane Q15 Saturating Multiplier

This block is an execution unit for packed fractional arithmetic. Each of its two 32-bit source operands carries two signed Q15 halfwords. The unit multiplies each halfword only with the halfword in the same position of the other operand. It doubles the 32-bit product to reach Q31 form and keeps the upper sixteen bits by plain truncation. The only product that cannot be represented, minus one times minus one, is clamped to the largest positive Q15 value.

The two lane results are packed into a 64-bit destination word. The upper lane result is sign-extended through the top 32 bits. Whenever a lane clamps, the unit issues a single one-cycle set strobe for the overflow flag of the surrounding control register, together with the fixed index 21 of the bit to set. Clearing that flag is left to the register's owner.

The output is registered. A result, its valid and its flag strobe appear one clock after the input is accepted.

Top module: `q15_pair_mul`

## Requirements
- R1: Lane 1 occupies operand bits 31..16 and lane 0 occupies bits 15..0. Each lane result depends only on the same lane of both operands.
- R2: For lanes that are not both 0x8000, the lane result is bits 31..16 of the signed 32-bit product shifted left by one. This is a truncation toward minus infinity with no rounding, so 0xFFFF times 0x0001 gives 0xFFFF.
- R3: When both halfwords of a lane equal 0x8000, that lane result is 0x7FFF.
- R4: If one or both lanes clamp, `flag_set` is high for exactly the one cycle in which the matching `out_valid` is high. It is a single strobe, whether one lane or both lanes clamp.
- R5: `flag_set` stays low for every accepted operand pair in which no lane is 0x8000 times 0x8000.
- R6: `result` bits 31..16 hold the lane 1 result and bits 15..0 hold the lane 0 result. Bits 63..32 are all copies of `result` bit 31.
- R7: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high. `result` then reflects the operands sampled at that edge.
- R8: After an edge at which `in_valid` was low, `out_valid` and `flag_set` are low and `result` keeps its previous value.
- R9: `flag_index` always reads 21.
- R10: While `rst_n` is low, `out_valid` is 0, `flag_set` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_a | input | 32 | First packed operand, two Q15 lanes |
| src_b | input | 32 | Second packed operand, two Q15 lanes |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Packed, sign-extended lane results |
| flag_set | output | 1 | One-cycle request to set the overflow flag bit |
| flag_index | output | 5 | Bit position of the overflow flag to set (21) |

## Verification
The assertions assume that `src_a` and `src_b` are meaningful only in cycles where `in_valid` is high. The clamp and flag properties therefore qualify their operand checks with `in_valid`. They also assume that `in_valid` is held low throughout reset, so the first `$past` sample after reset shows an idle input. The bench drives operands and `in_valid` only on falling edges. It keeps `in_valid` low during reset. It mixes idle cycles into every phase, so that the hold and no-strobe properties are exercised as often as the active ones.

// File: rtl/q15_pair_pkg.sv
`timescale 1ns/1ps
package q15_pair_pkg;
  localparam int unsigned DEF_LANE_W   = 16;
  localparam int unsigned DEF_LANES    = 2;
  localparam int unsigned DEF_RES_W    = 64;
  localparam int unsigned DEF_FLAG_BIT = 21;

  // Width needed to carry a bit index up to and including max_bit.
  function automatic int unsigned idx_width(input int unsigned max_bit);
    return (max_bit < 2) ? 1 : $clog2(max_bit + 1);
  endfunction
endpackage

// File: rtl/q15_lane_mul.sv
`timescale 1ns/1ps
module q15_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] lane_res,
  output logic         lane_sat
);
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  // Full-width signed product of two fractional lanes.
  function automatic logic signed [PW-1:0] frac_product(input logic [W-1:0] a,
                                                        input logic [W-1:0] b);
    logic signed [PW-1:0] wa;
    logic signed [PW-1:0] wb;
    wa = $signed({{W{a[W-1]}}, a});
    wb = $signed({{W{b[W-1]}}, b});
    return wa * wb;
  endfunction

  // Doubling into the wide fractional format, then truncation to the high half.
  function automatic logic [W-1:0] frac_high(input logic signed [PW-1:0] p);
    logic [PW-1:0] dbl;
    dbl = {p[PW-2:0], 1'b0};
    return dbl[PW-1:W];
  endfunction

  logic signed [PW-1:0] product;
  logic                 corner;

  always_comb begin
    product  = frac_product(op_a, op_b);
    corner   = (op_a == MOST_NEG) && (op_b == MOST_NEG);
    lane_res = corner ? MOST_POS : frac_high(product);
    lane_sat = corner;
  end
endmodule

// File: rtl/q15_lane_pack.sv
`timescale 1ns/1ps
module q15_lane_pack #(
  parameter int unsigned W     = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned RES_W = 64
) (
  input  logic [LANES*W-1:0] lanes_in,
  output logic [RES_W-1:0]   packed_out
);
  localparam int unsigned PAIR_W = LANES * W;
  localparam int unsigned FILL_W = RES_W - PAIR_W;

  generate
    if (FILL_W > 0) begin : g_fill
      assign packed_out = {{FILL_W{lanes_in[PAIR_W-1]}}, lanes_in};
    end else begin : g_nofill
      assign packed_out = lanes_in[RES_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/q15_out_stage.sv
`timescale 1ns/1ps
module q15_out_stage #(
  parameter int unsigned RES_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [RES_W-1:0] d_result,
  input  logic             d_sat,
  output logic             q_valid,
  output logic [RES_W-1:0] q_result,
  output logic             q_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_flag   <= 1'b0;
    end else begin
      q_valid <= d_valid;
      q_flag  <= d_valid & d_sat;
      if (d_valid) begin
        q_result <= d_result;
      end
    end
  end
endmodule

// File: rtl/q15_pair_mul.sv
`timescale 1ns/1ps
module q15_pair_mul
  import q15_pair_pkg::*;
#(
  parameter int unsigned LANE_W   = DEF_LANE_W,
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned RES_W    = DEF_RES_W,
  parameter int unsigned FLAG_BIT = DEF_FLAG_BIT,
  localparam int unsigned PAIR_W  = LANES * LANE_W,
  localparam int unsigned FIDX_W  = idx_width(FLAG_BIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PAIR_W-1:0] src_a,
  input  logic [PAIR_W-1:0] src_b,
  output logic              out_valid,
  output logic [RES_W-1:0]  result,
  output logic              flag_set,
  output logic [FIDX_W-1:0] flag_index
);
  // Named internal events, visible to the bound checker.
  logic [LANES-1:0]  lane_sat;
  logic [PAIR_W-1:0] lane_word;
  logic [RES_W-1:0]  packed_word;
  logic              any_sat;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      q15_lane_mul #(.W(LANE_W)) u_lane (
        .op_a     (src_a[i*LANE_W +: LANE_W]),
        .op_b     (src_b[i*LANE_W +: LANE_W]),
        .lane_res (lane_word[i*LANE_W +: LANE_W]),
        .lane_sat (lane_sat[i])
      );
    end
  endgenerate

  assign any_sat = |lane_sat;

  q15_lane_pack #(.W(LANE_W), .LANES(LANES), .RES_W(RES_W)) u_pack (
    .lanes_in   (lane_word),
    .packed_out (packed_word)
  );

  q15_out_stage #(.RES_W(RES_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (in_valid),
    .d_result (packed_word),
    .d_sat    (any_sat),
    .q_valid  (out_valid),
    .q_result (result),
    .q_flag   (flag_set)
  );

  assign flag_index = FIDX_W'(FLAG_BIT);
endmodule

// File: rtl/q15_pair_mul_chk.sv
`timescale 1ns/1ps
module q15_pair_mul_chk #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RES_W  = 64,
  localparam int unsigned PAIR_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PAIR_W-1:0] src_a,
  input logic [PAIR_W-1:0] src_b,
  input logic              out_valid,
  input logic [RES_W-1:0]  result,
  input logic              flag_set,
  input logic [LANES-1:0]  lane_sat
);
  localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};
  localparam int unsigned TOP = (LANES - 1) * LANE_W;

  function automatic logic any_corner(input logic [PAIR_W-1:0] a,
                                      input logic [PAIR_W-1:0] b);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (a[i*LANE_W +: LANE_W] == MOST_NEG && b[i*LANE_W +: LANE_W] == MOST_NEG) hit = 1'b1;
    end
    return hit;
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !flag_set)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R8
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[RES_W-1:PAIR_W] == {(RES_W-PAIR_W){result[PAIR_W-1]}})); // R6
  AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a[TOP +: LANE_W] == MOST_NEG && src_b[TOP +: LANE_W] == MOST_NEG)
      |=> (result[TOP +: LANE_W] == MOST_POS)); // R3
  AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a[LANE_W-1:0] == MOST_NEG && src_b[LANE_W-1:0] == MOST_NEG)
      |=> (result[LANE_W-1:0] == MOST_POS)); // R3
  AST_FLAG_ON_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|lane_sat)) |=> (flag_set && out_valid)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> ($past(in_valid) && any_corner($past(src_a), $past(src_b)))); // R5
endmodule

bind q15_pair_mul q15_pair_mul_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
  .out_valid(out_valid), .result(result), .flag_set(flag_set), .lane_sat(lane_sat)
);

// File: tb/q15_pair_mul_bench.sv
`timescale 1ns/1ps
module q15_pair_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_set;
  logic [4:0]  flag_index;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // Reference state of the model.
  bit          exp_valid = 1'b0;
  bit          exp_flag  = 1'b0;
  logic [63:0] exp_result = '0;
  bit          exp_hi_corner = 1'b0;
  bit          exp_lo_corner = 1'b0;

  always #2.5 clk = ~clk;

  q15_pair_mul u_q15_pair_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .flag_set(flag_set), .flag_index(flag_index)
  );

  // Integer model: value of a*b in Q30, times two, floor-divided by 2^16.
  function automatic logic [15:0] model_lane(input logic [15:0] a, input logic [15:0] b);
    longint va, vb, q31, hi;
    va = longint'($signed(a));
    vb = longint'($signed(b));
    if (va == -32768 && vb == -32768) return 16'h7FFF;
    q31 = va * vb * 2;
    hi = q31 >>> 16;
    return hi[15:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, expv, $time);
    end
  endtask

  task automatic check_outputs();
    string rh, rl;
    check("R7/R8 out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
    check(exp_flag ? "R4 flag_set" : "R5 flag_set", {63'd0, flag_set}, {63'd0, exp_flag});
    check("R9 flag_index", {59'd0, flag_index}, 64'd21);
    check("R6 sign fill", {32'd0, result[63:32]}, {32'd0, exp_result[63:32]});
    rh = exp_hi_corner ? "R1/R3 lane1" : "R1/R2 lane1";
    rl = exp_lo_corner ? "R1/R3 lane0" : "R1/R2 lane0";
    check(rh, {48'd0, result[31:16]}, {48'd0, exp_result[31:16]});
    check(rl, {48'd0, result[15:0]}, {48'd0, exp_result[15:0]});
  endtask

  // Drive one cycle of stimulus and advance the model.
  task automatic apply(input bit v, input logic [31:0] a, input logic [31:0] b);
    logic [15:0] hi, lo;
    in_valid = v;
    src_a = a;
    src_b = b;
    if (v) begin
      hi = model_lane(a[31:16], b[31:16]);
      lo = model_lane(a[15:0], b[15:0]);
      exp_hi_corner = (a[31:16] == 16'h8000) && (b[31:16] == 16'h8000);
      exp_lo_corner = (a[15:0] == 16'h8000) && (b[15:0] == 16'h8000);
      exp_result = {{32{hi[15]}}, hi, lo};
      exp_flag  = exp_hi_corner || exp_lo_corner;
      exp_valid = 1'b1;
    end else begin
      exp_flag  = 1'b0;
      exp_valid = 1'b0;
    end
    @(negedge clk);
    check_outputs();
  endtask

  initial begin : watchdog
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R10: reset state.
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R10 flag_set in reset", {63'd0, flag_set}, 64'd0);
    check("R10 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();

    apply(1, 32'h8000_8000, 32'h8000_8000); // R3, R4: both lanes clamp, one strobe
    apply(1, 32'h8000_1234, 32'h8000_4000); // R3 on lane 1 only
    apply(1, 32'h4000_8000, 32'h2000_8000); // R3 on lane 0 only
    apply(1, 32'h8000_7FFF, 32'h7FFF_8000); // R5: most negative times most positive
    apply(1, 32'h8000_8000, 32'h7FFF_0001); // R5: no matching corner
    apply(0, 32'h8000_8000, 32'h8000_8000); // R8: corner operands ignored when idle
    apply(0, 32'h0000_0000, 32'h0000_0000); // R8: hold again
    apply(1, 32'h0000_0000, 32'h1234_8000); // zero operands
    apply(1, 32'hFFFF_0001, 32'h0001_FFFF); // R2: truncation toward minus infinity
    apply(1, 32'h4000_C000, 32'h4000_4000); // R6: positive top lane, negative lower lane
    apply(1, 32'hC000_4000, 32'h4000_4000); // R6: negative top lane fills ones
    apply(1, 32'h7FFF_7FFF, 32'h7FFF_7FFF); // largest non-saturating product
    apply(1, 32'h0001_0000, 32'h0000_0001); // R1: lanes do not cross
    apply(0, 32'h0, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      int sel;
      a = $urandom;
      b = $urandom;
      sel = $urandom_range(0, 15);
      if (sel == 0) begin a[31:16] = 16'h8000; b[31:16] = 16'h8000; end
      if (sel == 1) begin a[15:0]  = 16'h8000; b[15:0]  = 16'h8000; end
      if (sel == 2) begin a[15:0]  = 16'h8000; end
      apply((sel % 5) != 4, a, b);
    end
    apply(0, 32'h0, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule